// File: doc/BRIEF.md
# PLL Power and Output-Gate Sequencer

This block controls a fixed-frequency PLL. A single 32-bit control word holds an output-gate bit and a power-enable bit, and nothing else in it is stored. Software reaches the word at three byte offsets. The plain offset overwrites it. The set offset turns on every bit written as one. The clear offset turns off every bit written as one. Rate selection is not part of this block: the PLL frequency is fixed, and no field of the word divides or multiplies it.

When power is raised, a settle timer counts reference-clock ticks. The timer needs a parameter number of ticks, which corresponds to about ten microseconds. Once the count has expired and the PLL reports lock, the block raises `ready`. The output enable goes high only when power is on, `ready` is high and the gate bit is clear. Dropping power restarts the settle sequence from zero. All pins are plain control and status levels, so no stream handshake applies.

Top module: `pll_pwr_gate_ctl`

## Requirements
- R1: After reset the word reads 0x8000_0000, with the gate bit (bit 31) set and power off. In this state `pll_pd` is 1, and `ready` and `out_en` are 0.
- R2: A write at offset 0x0 loads bit 31 and bit PWR_BIT from the write data. Every other bit reads as 0.
- R3: A write at offset 0x4 sets each stored bit whose write-data bit is 1. Stored bits whose write-data bit is 0 keep their value.
- R4: A write at offset 0x8 clears each stored bit whose write-data bit is 1. Stored bits whose write-data bit is 0 keep their value.
- R5: A read at 0x0, 0x4 or 0x8 returns the stored word. A read at any other address returns 0, and a write at any other address changes nothing.
- R6: `pll_pd` is the inverse of the stored power bit.
- R7: With lock high, `ready` rises on the clock edge that counts the SETTLE_TICKS-th `ref_tick` pulse after power was set. Cycles without a tick do not advance the count.
- R8: Clearing power drops `ready` in the same cycle the stored bit clears. Raising power again requires a full new count of SETTLE_TICKS ticks.
- R9: `out_en` is 1 exactly when power is on, `ready` is 1 and bit 31 is 0. Setting bit 31 removes the output at once.
- R10: `ready` and `out_en` are 0 whenever `pll_lock` is 0, even after the settle count has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_pd | output | 1 | PLL power-down, high when power is off |
| out_en | output | 1 | PLL output enable |
| ready | output | 1 | Settle time has elapsed and the PLL is locked |

## Verification
A wrong settle counter appears on `ready` in two ways. `ready` can rise one or more ticks too early or too late, or it can stay high after a power cycle instead of falling. Either error is visible on the first cycle after the offending tick or write. A wrong alias decode or a wrong stored bit appears on the next read of any alias, and on `pll_pd` or `out_en` one cycle after the write. The bench therefore sweeps the tick count around the threshold and reads back after every write.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int unsigned GATE_BIT = 31;
  localparam logic [3:0] OFF_PLAIN = 4'h0;
  localparam logic [3:0] OFF_SET   = 4'h4;
  localparam logic [3:0] OFF_CLR   = 4'h8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PLAIN = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLR   = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic gate;
    logic pwr;
  } ctl_bits_t;
endpackage

// File: rtl/pll_ctl_regfile.sv
module pll_ctl_regfile
  import pll_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned PWR_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output ctl_bits_t         ctl
);
  acc_kind_t kind;
  logic      wd_gate, wd_pwr;

  always_comb begin
    kind = ACC_NONE;
    if (bus_addr == ADDR_W'(OFF_PLAIN))    kind = ACC_PLAIN;
    else if (bus_addr == ADDR_W'(OFF_SET)) kind = ACC_SET;
    else if (bus_addr == ADDR_W'(OFF_CLR)) kind = ACC_CLR;
  end

  assign wd_gate = bus_wdata[GATE_BIT];
  assign wd_pwr  = bus_wdata[PWR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.gate <= 1'b1;
      ctl.pwr  <= 1'b0;
    end else if (bus_we) begin
      unique case (kind)
        ACC_PLAIN: begin ctl.gate <= wd_gate;            ctl.pwr <= wd_pwr; end
        ACC_SET:   begin ctl.gate <= ctl.gate | wd_gate; ctl.pwr <= ctl.pwr | wd_pwr; end
        ACC_CLR:   begin ctl.gate <= ctl.gate & ~wd_gate; ctl.pwr <= ctl.pwr & ~wd_pwr; end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (kind != ACC_NONE) begin
      bus_rdata[GATE_BIT] = ctl.gate;
      bus_rdata[PWR_BIT]  = ctl.pwr;
    end
  end

  AST_SET_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && kind == ACC_SET && wd_pwr) |=> ctl.pwr); // R3
  AST_CLR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && kind == ACC_CLR && wd_gate) |=> !ctl.gate); // R4
  AST_STRAY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_NONE) |=> $stable(ctl)); // R5
endmodule

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int unsigned SETTLE_TICKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic ref_tick,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!pwr)                     cnt <= '0;
    else if (ref_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = pwr && (cnt == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> (cnt == '0)); // R8
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(pwr)) |-> $past(ref_tick)); // R7
endmodule

// File: rtl/pll_pwr_gate_ctl.sv
module pll_pwr_gate_ctl
  import pll_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned PWR_BIT      = 16,
  parameter int unsigned SETTLE_TICKS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  input  logic              pll_lock,
  output logic              pll_pd,
  output logic              out_en,
  output logic              ready
);
  ctl_bits_t ctl;
  logic      settled;

  pll_ctl_regfile #(.ADDR_W(ADDR_W), .PWR_BIT(PWR_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ctl(ctl)
  );

  pll_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr(ctl.pwr), .ref_tick(ref_tick), .done(settled)
  );

  assign pll_pd = ~ctl.pwr;
  assign ready  = settled & pll_lock;
  assign out_en = ctl.pwr & ready & ~ctl.gate;

  AST_OUTEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !ctl.gate); // R9
  AST_PD_OUTEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !pll_pd); // R6
  AST_READY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pll_lock); // R10
endmodule

// File: tb/tb_pll_pwr_gate_ctl.sv
`timescale 1ns/1ps
module tb_pll_pwr_gate_ctl;
  localparam int unsigned PB = 5;
  localparam int unsigned ST = 4;
  localparam logic [31:0] G = 32'h8000_0000;
  localparam logic [31:0] P = 32'h1 << PB;

  logic clk = 0, rst_n = 0, bus_we = 0, ref_tick = 0, pll_lock = 1;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pll_pd, out_en, ready;
  int checks = 0, fails = 0;
  logic done = 0;

  always #4 clk = ~clk;

  pll_pwr_gate_ctl #(.ADDR_W(4), .PWR_BIT(PB), .SETTLE_TICKS(ST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .pll_lock(pll_lock), .pll_pd(pll_pd), .out_en(out_en), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; #1;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1;
      @(negedge clk); ref_tick = 0;
      repeat (gap) @(negedge clk);
    end
    #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    rd("R1", 4'h0, G);
    chk("R1 pd", pll_pd, 1); chk("R1 ready", ready, 0); chk("R1 out_en", out_en, 0);
    // R5 every alias reads the word, stray offset reads zero
    rd("R5 set", 4'h4, G); rd("R5 clr", 4'h8, G); rd("R5 stray", 4'hC, 0);
    // R5 stray write ignored
    wr(4'hC, 32'hFFFF_FFFF); rd("R5 stray wr", 4'h0, G);
    // R2 plain write, other bits read zero
    wr(4'h0, 32'hFFFF_FFFF); rd("R2 all", 4'h0, G | P);
    wr(4'h0, 32'h0);         rd("R2 zero", 4'h0, 0);
    chk("R6 pd off", pll_pd, 1);
    // R3 set with zero data changes nothing, then set gate
    wr(4'h4, 32'h0); rd("R3 noop", 4'h0, 0);
    wr(4'h4, G);     rd("R3 gate", 4'h0, G);
    // R7 tick-count sweep around the threshold, with and without gaps
    for (int gap = 0; gap < 3; gap++) begin
      for (int n = 0; n <= ST + 2; n++) begin
        wr(4'h8, P);
        wr(4'h4, P);
        chk("R6 pd on", pll_pd, 0);
        ticks(n, gap);
        chk("R7 ready", ready, (n >= ST) ? 1 : 0);
        chk("R9 gated", out_en, 0);
      end
    end
    // R4 clear gate: output enabled
    wr(4'h8, G); rd("R4 clr gate", 4'h4, P);
    chk("R9 on", out_en, 1);
    // R10 lock loss
    pll_lock = 0; #1;
    chk("R10 ready", ready, 0); chk("R10 out_en", out_en, 0);
    pll_lock = 1; #1;
    chk("R10 back", out_en, 1);
    // R9 regate
    wr(4'h4, G); chk("R9 regate", out_en, 0);
    wr(4'h8, G); chk("R9 ungate", out_en, 1);
    // R8 power drop and restart
    wr(4'h8, P); chk("R8 drop", ready, 0); chk("R8 out", out_en, 0);
    wr(4'h4, P); chk("R8 restart", ready, 0);
    ticks(ST - 1, 1); chk("R8 partial", ready, 0);
    ticks(1, 0); chk("R8 full", ready, 1); chk("R9 final", out_en, 1);
    // R4 clear with zero data keeps word
    wr(4'h8, 32'h0); rd("R4 noop", 4'h0, P);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule